// File: doc/BRIEF.md
# I2C Master Transmitter with Bus Stall

This block is a single-master I2C transmitter. Software sets a 7-bit target address and then writes bytes into a one-deep transmit holding register. The first write to an idle block starts a transfer: the block drives START, sends the address with a write direction bit, and then sends each held byte in turn. After every byte it releases SDA for the ninth clock and samples the target's acknowledge.

When the holding register is empty at the end of a byte, the block does not end the transfer. It holds SCL low and waits. A new byte releases SCL, and the transfer continues. The bus is released with a STOP only when software issues a stop command. Three status flags report whether the holding register is free, whether the last transfer has ended, and whether a target refused a byte. Each flag has its own enable, and the enabled flags combine into one interrupt line.

SCL timing comes from two divider inputs, one for the low phase and one for the high phase, both counted in system clocks. Both bus lines are open-drain. Each has a pull-low enable output and a line input, and the line input is synchronized with two flops. The high phase is counted only once the synchronized SCL reads high.

Top module: `i2c_wr_master`

## Requirements
- R1: A transfer begins with SDA falling while SCL is high. The first byte on the bus is the 7-bit address, MSB first, followed by a direction bit of 0 (the byte value is address*2).
- R2: Data bytes follow the address MSB first, in the order they were written. Each byte is followed by a ninth clock during which the block releases SDA.
- R3: The acknowledge is sampled at the end of the ninth SCL high phase. If SDA is high there, `nack` goes to 1 and stays at 1 until the next transfer starts. After a refusal, no further byte is sent and the holding register keeps its byte.
- R4: `txrdy` is 1 when the holding register is empty. It is 1 after reset. It is 0 from the cycle after a write. It returns to 1 when an acknowledged byte boundary moves the held byte into the shifter.
- R5: If the holding register is empty after an acknowledged byte, SCL is held low with no STOP for as long as needed. A later write resumes the transfer with that byte.
- R6: A STOP (SDA rising while SCL is high) is produced only after `stop_cmd`, and any byte still held is discarded. `stop_cmd` while idle has no effect.
- R7: `txcomp` is 1 after reset and again once a STOP has completed. It goes to 0 on the second cycle after a write to an idle block, when the transfer starts.
- R8: `irq` is the OR of each status flag ANDed with its enable bit: `ien[0]` enables `txrdy`, `ien[1]` enables `txcomp`, and `ien[2]` enables `nack`.
- R9: Apart from START and STOP, SDA changes only while SCL is low, so the bus shows exactly one START and one STOP per transfer.
- R10: Within a byte, every SCL low phase lasts `div_low` cycles. Every SCL high phase lasts `div_high` cycles counted from when the synchronized SCL reads high, which is `div_high`+2 cycles on a bus with no stretching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_we | input | 1 | Load `addr_in` as the target address |
| addr_in | input | 7 | Target address |
| thr_we | input | 1 | Write `thr_in` into the holding register |
| thr_in | input | 8 | Byte to transmit |
| stop_cmd | input | 1 | Request a STOP at the next byte boundary |
| ien | input | 3 | Interrupt enables {nack, txcomp, txrdy} |
| div_low | input | DIV_W | SCL low phase in clocks (at least 2) |
| div_high | input | DIV_W | SCL high phase in clocks (at least 2) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| txrdy | output | 1 | Holding register empty |
| txcomp | output | 1 | No transfer in progress, STOP done |
| nack | output | 1 | Sticky refusal flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench acts as a target on a modelled open-drain bus. It decodes START, STOP, bytes and SCL phase lengths over a sweep of divider settings, and it can refuse any chosen byte.

- **Stall.** It holds the block with an empty holding register to confirm the stall. A design that ended the transfer on its own would show an early STOP.
- **Refusal.** It refuses the address byte in one transfer and a data byte in another. A design that ignored the refusal, or cleared the flag at STOP, would send an extra byte or lose `nack`.
- **Stop command.** It issues the stop command while idle. A design that did not ignore it would put a stray STOP or clock on the bus.
- **Interrupt.** It sweeps all interrupt enables against known status. A design with a swapped enable bit would raise `irq` with the wrong flag.

// File: rtl/i2cw_pkg.sv
// Shared types for the I2C master transmitter.
// Assumes: one master on the bus, 7-bit addressing, write only.
package i2cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_REL
    } i2cw_state_e;

    localparam int STAT_W      = 3;
    localparam int STAT_TXRDY  = 0;
    localparam int STAT_TXCOMP = 1;
    localparam int STAT_NACK   = 2;
endpackage

// File: rtl/i2cw_sync.sv
// Two-flop synchronizer for one bus line input.
// Assumes: the line idles high, so reset loads 1.
module i2cw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Move the asynchronous line level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            q      <= 1'b1;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/i2cw_phase_timer.sv
// Counts the clocks of one SCL phase.
// done is high in the last enabled cycle of the phase.
// Assumes: limit >= 1, and clr pulses on every phase change.
module i2cw_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = en && (cnt_q == limit - 1'b1);

    // Advance while enabled; restart on a phase change or at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr || done) cnt_q <= '0;
        else if (en)         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2cw_status.sv
// Holding-register occupancy, sticky status flags and the masked interrupt.
// Assumes: a write has priority over take/flush in the same cycle.
module i2cw_status
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              thr_wr,
    input  logic              thr_take,
    input  logic              thr_flush,
    input  logic              nack_set,
    input  logic              stop_done,
    input  logic [STAT_W-1:0] ien,
    output logic              thr_full,
    output logic              txrdy,
    output logic              txcomp,
    output logic              nack,
    output logic              irq
);
    logic [STAT_W-1:0] stat;

    // Track whether the holding register has a byte waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                    thr_full <= 1'b0;
        else if (thr_wr)               thr_full <= 1'b1;
        else if (thr_take || thr_flush) thr_full <= 1'b0;
    end

    // Sticky refusal flag, cleared when the next transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n)          nack <= 1'b0;
        else if (xfer_start) nack <= 1'b0;
        else if (nack_set)   nack <= 1'b1;
    end

    // Transfer-complete flag: idle after reset, set once STOP finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)          txcomp <= 1'b1;
        else if (xfer_start) txcomp <= 1'b0;
        else if (stop_done)  txcomp <= 1'b1;
    end

    assign txrdy = !thr_full;

    assign stat[STAT_TXRDY]  = txrdy;
    assign stat[STAT_TXCOMP] = txcomp;
    assign stat[STAT_NACK]   = nack;
    assign irq = |(stat & ien);
endmodule

// File: rtl/i2c_wr_master.sv
// I2C master transmitter: START, address+W, data bytes with acknowledge
// sampling, a stall on an empty holding register, and STOP on command only.
// Assumes: single master; div_low and div_high are at least 2; the pads are
// open-drain, so *_oe = 1 pulls the line low.
module i2c_wr_master
    import i2cw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_we,
    input  logic [6:0]       addr_in,
    input  logic             thr_we,
    input  logic [7:0]       thr_in,
    input  logic             stop_cmd,
    input  logic [2:0]       ien,
    input  logic [DIV_W-1:0] div_low,
    input  logic [DIV_W-1:0] div_high,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             txrdy,
    output logic             txcomp,
    output logic             nack,
    output logic             irq
);
    localparam int BITS  = 8;
    localparam int CNT_W = $clog2(BITS + 1);
    localparam int LINES = 2;

    i2cw_state_e      state_q, state_d;
    logic [6:0]       addr_q;
    logic [7:0]       thr_q;
    logic [7:0]       shift_q, shift_d;
    logic [CNT_W-1:0] bit_q, bit_d;
    logic             stop_pend_q;
    logic             sda_drive;
    logic             thr_full;
    logic             ack_slot;
    logic             tmr_en, tmr_done, tmr_clr;
    logic [DIV_W-1:0] tmr_limit;
    logic             xfer_start, thr_take, thr_flush, nack_set, stop_done;
    logic [LINES-1:0] line_raw, line_sync;
    logic             scl_s, sda_s;

    // One synchronizer per bus line.
    assign line_raw = {sda_in, scl_in};
    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2cw_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (line_raw[g]),
            .q    (line_sync[g])
        );
    end
    assign scl_s = line_sync[0];
    assign sda_s = line_sync[1];

    // Pick the phase length and gate the high phases on the real SCL level.
    assign ack_slot  = (bit_q == CNT_W'(BITS));
    assign tmr_limit = (state_q == ST_LOW || state_q == ST_STOP_LOW) ? div_low : div_high;
    always_comb begin
        case (state_q)
            ST_HIGH, ST_STOP_HIGH:          tmr_en = scl_s;
            ST_START, ST_LOW, ST_STOP_LOW,
            ST_STOP_REL:                    tmr_en = 1'b1;
            default:                        tmr_en = 1'b0;
        endcase
    end
    assign tmr_clr = (state_d != state_q);

    i2cw_phase_timer #(.W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .limit(tmr_limit),
        .done (tmr_done)
    );

    // Sequence the bus phases, byte boundaries and the stall.
    always_comb begin
        state_d    = state_q;
        shift_d    = shift_q;
        bit_d      = bit_q;
        xfer_start = 1'b0;
        thr_take   = 1'b0;
        thr_flush  = 1'b0;
        nack_set   = 1'b0;
        stop_done  = 1'b0;
        case (state_q)
            ST_IDLE: if (thr_full) begin
                xfer_start = 1'b1;
                state_d    = ST_START;
            end
            ST_START: if (tmr_done) begin
                shift_d = {addr_q, 1'b0};
                bit_d   = '0;
                state_d = ST_LOW;
            end
            ST_LOW: if (tmr_done) state_d = ST_HIGH;
            ST_HIGH: if (tmr_done) begin
                if (!ack_slot) begin
                    shift_d = {shift_q[6:0], 1'b0};
                    bit_d   = bit_q + 1'b1;
                    state_d = ST_LOW;
                end else begin
                    nack_set = sda_s;
                    if (!sda_s && thr_full) begin
                        thr_take = 1'b1;
                        shift_d  = thr_q;
                        bit_d    = '0;
                        state_d  = ST_LOW;
                    end else if (stop_pend_q) begin
                        thr_flush = 1'b1;
                        state_d   = ST_STOP_LOW;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (thr_full && !nack) begin
                    thr_take = 1'b1;
                    shift_d  = thr_q;
                    bit_d    = '0;
                    state_d  = ST_LOW;
                end else if (stop_pend_q) begin
                    thr_flush = 1'b1;
                    state_d   = ST_STOP_LOW;
                end
            end
            ST_STOP_LOW:  if (tmr_done) state_d = ST_STOP_HIGH;
            ST_STOP_HIGH: if (tmr_done) state_d = ST_STOP_REL;
            ST_STOP_REL: if (tmr_done) begin
                stop_done = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // SDA level wanted by the current phase; the ninth bit releases the line.
    always_comb begin
        case (state_q)
            ST_START, ST_STOP_LOW, ST_STOP_HIGH: sda_drive = 1'b1;
            ST_LOW, ST_HIGH:                     sda_drive = !ack_slot && !shift_q[7];
            default:                             sda_drive = 1'b0;
        endcase
    end

    assign scl_oe = (state_q == ST_LOW) || (state_q == ST_HOLD) || (state_q == ST_STOP_LOW);

    // Phase state, shifter and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            bit_q   <= bit_d;
        end
    end

    // Delay SDA by one clock so it moves only after SCL has gone low.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_oe <= 1'b0;
        else        sda_oe <= sda_drive;
    end

    // Software-loaded address and holding byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            thr_q  <= '0;
        end else begin
            if (addr_we) addr_q <= addr_in;
            if (thr_we)  thr_q  <= thr_in;
        end
    end

    // Remember a stop request made during a transfer until the STOP is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_pend_q <= 1'b0;
        else if (stop_done) stop_pend_q <= 1'b0;
        else if (stop_cmd && (state_q == ST_START || state_q == ST_LOW ||
                              state_q == ST_HIGH || state_q == ST_HOLD))
            stop_pend_q <= 1'b1;
    end

    i2cw_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_start(xfer_start),
        .thr_wr    (thr_we),
        .thr_take  (thr_take),
        .thr_flush (thr_flush),
        .nack_set  (nack_set),
        .stop_done (stop_done),
        .ien       (ien),
        .thr_full  (thr_full),
        .txrdy     (txrdy),
        .txcomp    (txcomp),
        .nack      (nack),
        .irq       (irq)
    );
endmodule

// File: rtl/i2cw_chk.sv
// Protocol checks for i2c_wr_master, attached with bind.
module i2cw_chk
    import i2cw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input i2cw_state_e state,
    input logic        stop_pend,
    input logic        thr_we,
    input logic        txrdy,
    input logic        txcomp,
    input logic        nack,
    input logic        irq,
    input logic [2:0]  ien,
    input logic        sda_oe
);
    // R4
    txrdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> !txrdy);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 3'b000) |-> !irq);

    // R8
    irq_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && ien[2]) |-> irq);

    // R3
    nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && !txcomp) |=> nack);

    // R9
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && $past(state == ST_HIGH)) |-> $stable(sda_oe));

    // R6
    stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txcomp) |-> $past(stop_pend));

    // R7
    txcomp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txcomp) |-> !txrdy);

    // R5
    hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !stop_pend && txrdy) |=> (state == ST_HOLD));
endmodule

bind i2c_wr_master i2cw_chk u_i2cw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .stop_pend(stop_pend_q),
    .thr_we   (thr_we),
    .txrdy    (txrdy),
    .txcomp   (txcomp),
    .nack     (nack),
    .irq      (irq),
    .ien      (ien),
    .sda_oe   (sda_oe)
);

// File: tb/test_i2c_wr_master.sv
// Bench: open-drain bus model with a target that decodes the bus and acknowledges.
module test_i2c_wr_master;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             addr_we = 1'b0;
    logic [6:0]       addr_in = '0;
    logic             thr_we = 1'b0;
    logic [7:0]       thr_in = '0;
    logic             stop_cmd = 1'b0;
    logic [2:0]       ien = '0;
    logic [DIV_W-1:0] div_low = 8'd3;
    logic [DIV_W-1:0] div_high = 8'd2;
    logic             scl_oe, sda_oe, txrdy, txcomp, nack, irq;
    logic             slv_pull = 1'b0;
    wire              scl_bus = !scl_oe;
    wire              sda_bus = !(sda_oe || slv_pull);

    int checks = 0;
    int errors = 0;

    // Target-side decode state
    bit         mon_on = 1'b0;
    bit         in_frame = 1'b0;
    int         bitn = 0;
    int         byte_idx = 0;
    logic [7:0] shreg = '0;
    logic [7:0] recv [0:127];
    logic       ackb [0:127];
    int         nrecv = 0;
    int         n_start = 0;
    int         n_stop = 0;
    logic [7:0] nack_mask = '0;
    time        t_fall = 0;
    time        t_rise = 0;
    int         lo_exp = 3;
    int         hi_exp = 2;
    int         tim_cnt = 0;
    int         tim_bad = 0;

    always #10 clk = ~clk;

    i2c_wr_master #(.DIV_W(DIV_W)) i_i2c_wr_master (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_in(addr_in),
        .thr_we(thr_we), .thr_in(thr_in), .stop_cmd(stop_cmd), .ien(ien),
        .div_low(div_low), .div_high(div_high), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .txrdy(txrdy), .txcomp(txcomp),
        .nack(nack), .irq(irq)
    );

    // START: SDA falls with SCL high
    always @(negedge sda_bus) if (mon_on && scl_bus === 1'b1) begin
        n_start++; in_frame = 1'b1; bitn = 0; byte_idx = 0;
    end

    // STOP: SDA rises with SCL high
    always @(posedge sda_bus) if (mon_on && scl_bus === 1'b1) begin
        n_stop++; in_frame = 1'b0;
    end

    // Sample bits on SCL rise and time the low phase inside a byte (R10)
    always @(posedge scl_bus) if (mon_on) begin
        if (in_frame) begin
            if (bitn >= 1 && bitn <= 7) begin
                tim_cnt++;
                if ($time - t_fall != lo_exp * 20) tim_bad++;
            end
            if (bitn < 8) begin
                shreg = {shreg[6:0], sda_bus}; bitn++;
            end else begin
                if (nrecv < 128) begin recv[nrecv] = shreg; ackb[nrecv] = sda_bus; end
                nrecv++; bitn = 0; byte_idx++;
            end
        end
        t_rise = $time;
    end

    // Drive the acknowledge and time the high phase inside a byte (R10)
    always @(negedge scl_bus) if (mon_on) begin
        if (in_frame && bitn >= 2 && bitn <= 8) begin
            tim_cnt++;
            if ($time - t_rise != (hi_exp + 2) * 20) tim_bad++;
        end
        if (in_frame && bitn == 8) slv_pull = !nack_mask[byte_idx % 8];
        else                       slv_pull = 1'b0;
        t_fall = $time;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_thr(input logic [7:0] d);
        @(negedge clk); thr_in = d; thr_we = 1'b1;
        @(negedge clk); thr_we = 1'b0;
    endtask

    task automatic set_addr(input logic [6:0] a);
        @(negedge clk); addr_in = a; addr_we = 1'b1;
        @(negedge clk); addr_we = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
    endtask

    task automatic wait_txrdy();
        while (!txrdy) @(negedge clk);
    endtask

    task automatic wait_txcomp();
        while (!txcomp) @(negedge clk);
    endtask

    task automatic wait_recv(input int n);
        while (nrecv < n) @(negedge clk);
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'((seed * 37 + i * 101 + 5) & 255);
    endfunction

    // One full transfer: queued bytes, stall, resume, then stop
    task automatic run_xfer(input int nb, input logic [6:0] a, input int seed);
        int s0; int p0; int r0; logic [7:0] d; bit acks_ok;
        s0 = n_start; p0 = n_stop; r0 = nrecv;
        nack_mask = '0;
        set_addr(a);
        for (int i = 0; i < nb; i++) begin
            d = byte_of(seed, i);
            wr_thr(d);
            if (i == 0) begin
                check(txrdy == 1'b0, "R4 txrdy after write", txrdy, 0);
                @(negedge clk);
                check(txcomp == 1'b0, "R7 txcomp at start", txcomp, 0);
            end
            wait_txrdy();
        end
        wait_recv(r0 + 1 + nb);
        repeat (60) @(negedge clk);
        check(scl_bus == 1'b0, "R5 SCL held low when empty", scl_bus, 0);
        check(n_stop == p0, "R6 no STOP without command", n_stop - p0, 0);
        check(txcomp == 1'b0, "R7 txcomp during stall", txcomp, 0);
        check(txrdy == 1'b1, "R4 txrdy after ack", txrdy, 1);
        d = byte_of(seed, nb);
        wr_thr(d);
        wait_recv(r0 + 2 + nb);
        check(recv[r0 + 1 + nb] == d, "R5 resume byte", recv[r0 + 1 + nb], d);
        repeat (30) @(negedge clk);
        pulse_stop();
        wait_txcomp();
        check(n_stop == p0 + 1, "R6 one STOP after command", n_stop - p0, 1);
        check(n_start == s0 + 1, "R9 one START per transfer", n_start - s0, 1);
        check(recv[r0] == {a, 1'b0}, "R1 address byte", recv[r0], {a, 1'b0});
        acks_ok = 1'b1;
        for (int i = 0; i < nb; i++) begin
            check(recv[r0 + 1 + i] == byte_of(seed, i), "R2 data byte",
                  recv[r0 + 1 + i], byte_of(seed, i));
        end
        for (int i = 0; i <= nb + 1; i++) if (ackb[r0 + i] !== 1'b0) acks_ok = 1'b0;
        check(acks_ok, "R2 ninth bit released and acknowledged", acks_ok, 1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0; int p0; int r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // Reset state
        check(scl_oe == 1'b0, "R6 SCL released at reset", scl_oe, 0);
        check(sda_oe == 1'b0, "R6 SDA released at reset", sda_oe, 0);
        check(txrdy == 1'b1, "R4 txrdy at reset", txrdy, 1);
        check(txcomp == 1'b1, "R7 txcomp at reset", txcomp, 1);
        check(nack == 1'b0, "R3 nack at reset", nack, 0);

        // Exhaustive enable sweep with status {nack=0, txcomp=1, txrdy=1}
        for (int e = 0; e < 8; e++) begin
            ien = 3'(e);
            @(negedge clk);
            check(irq == ((e & 3) != 0), "R8 irq mask idle", irq, int'((e & 3) != 0));
        end
        ien = '0;

        // Stop command while idle is ignored
        s0 = n_start; p0 = n_stop;
        pulse_stop();
        repeat (50) @(negedge clk);
        check(n_stop == p0 && n_start == s0, "R6 idle stop ignored", n_stop - p0, 0);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R6 idle bus untouched", scl_oe, 0);
        check(txcomp == 1'b1, "R7 idle txcomp", txcomp, 1);

        // Divider sweep
        for (int lo = 2; lo <= 4; lo++) begin
            for (int hi = 2; hi <= 4; hi++) begin
                div_low = 8'(lo); div_high = 8'(hi);
                lo_exp = lo; hi_exp = hi;
                tim_cnt = 0; tim_bad = 0;
                run_xfer(1 + (lo + hi) % 3, 7'((lo * 29 + hi * 13) & 127), lo * 5 + hi);
                check(tim_bad == 0 && tim_cnt > 0, "R10 SCL phase lengths", tim_bad, 0);
            end
        end

        // Refused address
        div_low = 8'd3; div_high = 8'd2; lo_exp = 3; hi_exp = 2;
        r0 = nrecv;
        nack_mask = 8'h01;
        set_addr(7'h2A);
        wr_thr(8'h5C);
        wait_recv(r0 + 1);
        repeat (100) @(negedge clk);
        check(nack == 1'b1, "R3 nack on address", nack, 1);
        check(nrecv == r0 + 1, "R3 no byte after refusal", nrecv - r0, 1);
        check(txrdy == 1'b0, "R3 holding kept after refusal", txrdy, 0);
        ien = 3'b100; @(negedge clk);
        check(irq == 1'b1, "R8 irq on nack", irq, 1);
        ien = 3'b011; @(negedge clk);
        check(irq == 1'b0, "R8 irq masked nack", irq, 0);
        pulse_stop();
        wait_txcomp();
        check(nack == 1'b1, "R3 nack sticky past STOP", nack, 1);
        check(txrdy == 1'b1, "R6 STOP discards held byte", txrdy, 1);
        ien = 3'b010; @(negedge clk);
        check(irq == 1'b1, "R8 irq on txcomp", irq, 1);
        ien = 3'b000; @(negedge clk);
        check(irq == 1'b0, "R8 irq all masked", irq, 0);

        // Refused data byte; a later write is not sent
        r0 = nrecv;
        nack_mask = 8'h02;
        set_addr(7'h15);
        wr_thr(8'hA7);
        @(negedge clk);
        check(nack == 1'b0, "R3 nack cleared at new start", nack, 0);
        wait_txrdy();
        wait_recv(r0 + 2);
        repeat (80) @(negedge clk);
        check(nack == 1'b1, "R3 nack on data byte", nack, 1);
        check(scl_bus == 1'b0, "R5 SCL held after refusal", scl_bus, 0);
        wr_thr(8'h3C);
        repeat (120) @(negedge clk);
        check(nrecv == r0 + 2, "R3 nothing sent after refusal", nrecv - r0, 2);
        pulse_stop();
        wait_txcomp();
        check(recv[r0 + 1] == 8'hA7, "R2 refused byte content", recv[r0 + 1], 8'hA7);

        // A normal transfer afterwards clears the flag
        run_xfer(2, 7'h63, 99);
        check(nack == 1'b0, "R3 nack clear after good transfer", nack, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule